// File: doc/BRIEF.md
# Real-Time Clock Time Register Freeze and Load Control

This block holds the host-visible BCD time and date of a real-time clock and the running counters behind them. A chain of BCD counters (seconds, minutes, hours, day of month, month, year, century) advances once for each pulse on a one-per-second tick input. Each cycle, a user copy of those counters follows them with a one-cycle lag, and the host reads and writes that copy through a small register bus.

Two bits in a control register change how the user copy behaves. The read-hold bit stops updates to the user copy so that a read of several bytes sees one consistent time. The edit bit also stops updates and lets the host write the time fields. When the host clears the edit bit, the edited values are loaded into the counters. This load happens only if a time field was written while the edit bit was set. The counters themselves never stop counting ticks.

Top module: `rtc_hold_regs`

## Requirements
- R1: After reset the control register reads 0. Time reads 00:00:00, day 01, month 01, year 00, and century equals the RST_CENT parameter (default 0x20).
- R2: With both control bits clear, a tick pulse advances the counters at the clock edge that samples it. The readable user copy shows the new value one edge later.
- R3: While the read-hold bit (control bit 0) is 1 and the edit bit is 0, the user copy holds its value and ticks still advance the counters.
- R4: When the read-hold bit is cleared, the user copy shows the current counter value one clock after the control write, with no tick needed.
- R5: Writes to the time fields (address 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 century) change the user copy only while the edit bit (control bit 1) is 1. At any other time they are ignored. While the edit bit is 1, the user copy does not follow the counters.
- R6: Clearing the edit bit after at least one time-field write loads the whole user copy into the counters at that edge. A tick sampled at the same edge is dropped.
- R7: Clearing the edit bit with no time-field write leaves the counters as they are, including the ticks they counted while the edit bit was set.
- R8: The record of a write is consumed when the edit bit falls. A later edit session with no writes therefore causes no load.
- R9: Seconds and minutes roll over from 59 to 00, and hours from 23 to 00, each carrying into the next field.
- R10: The day rolls over to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is a multiple of 4 and 28 otherwise. All other months have 31 days. Month 12 rolls over to 01 and carries into the year.
- R11: Year 99 rolls over to 00 and carries into the century. Century 99 rolls over to 00.
- R12: Address 0 reads the control register, with read-hold in bit 0, edit in bit 1 and 0 in the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | ADDR_W | Register address, 0 control, 1 to 7 time fields |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data of the addressed register |

## Verification
The assertions check four relations on every cycle:
- the user copy lags the counters by exactly one cycle when neither hold is set;
- the user copy stays still under read-hold alone;
- the counters move only on a tick or a load, and a load copies the user copy exactly;
- the write record never survives outside an edit session.

Calendar correctness can only be shown by the bench's scenarios. These cover month lengths, leap years and year and century carries, and check that a load really carries the written value. They also show that a release of the read-hold becomes visible one clock later, and that ignored writes leave no trace.

// File: rtl/rtc_hold_pkg.sv
package rtc_hold_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;
    localparam int IDX_W      = $clog2(NUM_FIELDS);

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_CENT = 6;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_EDIT_BIT = 1;

    typedef logic [FIELD_W-1:0] bcd_t;
    typedef bcd_t [NUM_FIELDS-1:0] tod_t;

    typedef struct packed {
        logic hold;
        logic edit;
        logic dirty;
        tod_t cnt;
        tod_t usr;
    } hold_state_t;

    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return v + bcd_t'(1);
    endfunction

    function automatic logic leap_year(input bcd_t yr);
        if (yr[4]) return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
        return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    endfunction

    function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_hold_pkg::*;
(
    input  bcd_t cur_i,
    input  bcd_t lo_i,
    input  bcd_t hi_i,
    input  logic cy_i,
    output bcd_t nxt_o,
    output logic cy_o
);

    logic at_top;

    always_comb begin
        at_top = (cur_i >= hi_i);
        cy_o   = cy_i && at_top;
        if (!cy_i)       nxt_o = cur_i;
        else if (at_top) nxt_o = lo_i;
        else             nxt_o = bcd_inc(cur_i);
    end

endmodule

// File: rtl/rtc_tod_chain.sv
module rtc_tod_chain
    import rtc_hold_pkg::*;
(
    input  tod_t now_i,
    input  logic step_i,
    output tod_t next_o
);

    localparam tod_t LO_BOUND = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    localparam tod_t HI_FIXED = {8'h99, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};

    tod_t                  hi_bound;
    logic [NUM_FIELDS:0]   cy;

    always_comb begin
        hi_bound        = HI_FIXED;
        hi_bound[F_DAY] = last_day(now_i[F_MON], now_i[F_YEAR]);
    end

    assign cy[0] = step_i;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rtc_bcd_field u_field (
            .cur_i (now_i[g]),
            .lo_i  (LO_BOUND[g]),
            .hi_i  (hi_bound[g]),
            .cy_i  (cy[g]),
            .nxt_o (next_o[g]),
            .cy_o  (cy[g+1])
        );
    end

    // R11: a carry out of the century field means every field restarted
    always_comb begin
        if (cy[NUM_FIELDS]) begin
            a_r11_full_wrap: assert (next_o == LO_BOUND);
        end
    end

endmodule

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs
    import rtc_hold_pkg::*;
#(
    parameter int   ADDR_W    = 3,
    parameter bcd_t RST_YEAR  = 8'h00,
    parameter bcd_t RST_CENT  = 8'h20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    output logic [FIELD_W-1:0] rd_data_o
);

    localparam tod_t RST_TOD = {RST_CENT, RST_YEAR, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    hold_state_t     s_d, s_q;
    tod_t            cnt_step;
    logic            ctrl_sel;
    logic            field_sel;
    logic            field_wr;
    logic            edit_fall;
    logic            load;
    logic [IDX_W-1:0] idx;

    rtc_tod_chain u_chain (
        .now_i  (s_q.cnt),
        .step_i (tick_i),
        .next_o (cnt_step)
    );

    always_comb begin
        s_d       = s_q;
        ctrl_sel  = (addr_i == '0);
        field_sel = !ctrl_sel && (addr_i <= ADDR_W'(NUM_FIELDS));
        idx       = IDX_W'(addr_i - ADDR_W'(1));
        field_wr  = wr_en_i && field_sel && s_q.edit;
        edit_fall = wr_en_i && ctrl_sel && s_q.edit && !wr_data_i[CTRL_EDIT_BIT];
        load      = edit_fall && s_q.dirty;

        s_d.cnt = load ? s_q.usr : cnt_step;

        if (field_wr)                    s_d.usr[idx] = wr_data_i;
        else if (!s_q.hold && !s_q.edit) s_d.usr      = s_q.cnt;

        if (wr_en_i && ctrl_sel) begin
            s_d.hold = wr_data_i[CTRL_HOLD_BIT];
            s_d.edit = wr_data_i[CTRL_EDIT_BIT];
        end

        if (field_wr)       s_d.dirty = 1'b1;
        else if (edit_fall) s_d.dirty = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{hold: 1'b0, edit: 1'b0, dirty: 1'b0, cnt: RST_TOD, usr: RST_TOD};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (ctrl_sel) begin
            rd_data_o = '0;
            rd_data_o[CTRL_HOLD_BIT] = s_q.hold;
            rd_data_o[CTRL_EDIT_BIT] = s_q.edit;
        end else if (field_sel) begin
            rd_data_o = s_q.usr[idx];
        end else begin
            rd_data_o = '0;
        end
    end

    a_r2_user_tracks_counters: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.hold && !s_q.edit) |=> (s_q.usr == $past(s_q.cnt)));

    a_r3_hold_keeps_user_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.hold && !s_q.edit) |=> $stable(s_q.usr));

    a_r6_load_copies_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |=> (s_q.cnt == $past(s_q.usr)));

    a_r7_counters_move_on_tick_or_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load) |=> $stable(s_q.cnt));

    a_r2_tick_moves_seconds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load) |=> (s_q.cnt[F_SEC] != $past(s_q.cnt[F_SEC])));

    a_r8_dirty_only_in_edit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.edit |-> !s_q.dirty);

endmodule

// File: tb/rtc_hold_regs_tb_top.sv
`timescale 1ns/1ps
module rtc_hold_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtc_hold_regs dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data)
    );

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: addr %0d got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] ce, yr, mo, dy, hr, mi, se);
        wr(0, 8'h02);
        wr(1, se); wr(2, mi); wr(3, hr); wr(4, dy); wr(5, mo); wr(6, yr); wr(7, ce);
        wr(0, 8'h00);
        @(negedge clk);
    endtask

    task automatic chk_all(input logic [7:0] ce, yr, mo, dy, hr, mi, se, input string tag);
        chk(1, se, tag); chk(2, mi, tag); chk(3, hr, tag); chk(4, dy, tag);
        chk(5, mo, tag); chk(6, yr, tag); chk(7, ce, tag);
    endtask

    task automatic t_reset();
        chk(0, 8'h00, "R1 control");
        chk_all(8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 reset time");
    endtask

    task automatic t_track();
        pulse_tick();
        chk(1, 8'h01, "R2 tick seen");
        chk(2, 8'h00, "R2 minutes unchanged");
    endtask

    task automatic t_ignored_write();
        set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h08, 8'h00, 8'h20);
        wr(1, 8'h45);
        chk(1, 8'h20, "R5 write without edit");
        pulse_tick();
        chk(1, 8'h21, "R5 counters untouched");
    endtask

    task automatic t_read_hold();
        set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h08, 8'h00, 8'h10);
        wr(0, 8'h01);
        chk(0, 8'h01, "R12 hold bit readback");
        pulse_tick(); pulse_tick(); pulse_tick();
        chk(1, 8'h10, "R3 frozen seconds");
        wr(1, 8'h45);
        chk(1, 8'h10, "R5 write under hold only");
        wr(0, 8'h00);
        @(negedge clk);
        chk(1, 8'h13, "R4 release one clock");
    endtask

    task automatic t_edit_load();
        set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h08, 8'h00, 8'h10);
        wr(0, 8'h02);
        chk(0, 8'h02, "R12 edit bit readback");
        pulse_tick(); pulse_tick();
        chk(1, 8'h10, "R5 frozen under edit");
        wr(1, 8'h40);
        chk(1, 8'h40, "R5 edit write");
        wr(0, 8'h00);
        @(negedge clk);
        chk(1, 8'h40, "R6 loaded seconds");
        chk(3, 8'h08, "R6 loaded hours");
        pulse_tick();
        chk(1, 8'h41, "R6 counts from load");
    endtask

    task automatic t_edit_no_change();
        set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h08, 8'h00, 8'h10);
        wr(0, 8'h02);
        pulse_tick(); pulse_tick(); pulse_tick();
        wr(0, 8'h00);
        @(negedge clk);
        chk(1, 8'h13, "R7 no load kept ticks");
        wr(0, 8'h02);
        wr(1, 8'h30);
        wr(0, 8'h00);
        @(negedge clk);
        chk(1, 8'h30, "R8 first session loads");
        wr(0, 8'h02);
        pulse_tick(); pulse_tick();
        wr(0, 8'h00);
        @(negedge clk);
        chk(1, 8'h32, "R8 second session no load");
    endtask

    task automatic t_roll_time();
        set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h12, 8'h05, 8'h59);
        pulse_tick();
        chk(1, 8'h00, "R9 seconds wrap"); chk(2, 8'h06, "R9 minute carry");
        set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h12, 8'h59, 8'h59);
        pulse_tick();
        chk(2, 8'h00, "R9 minutes wrap"); chk(3, 8'h13, "R9 hour carry");
    endtask

    task automatic t_roll_date();
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk(4, 8'h29, "R10 leap day"); chk(5, 8'h02, "R10 leap month"); chk(3, 8'h00, "R9 hours wrap");
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk(4, 8'h01, "R10 after leap day"); chk(5, 8'h03, "R10 march");
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk(4, 8'h01, "R10 common feb"); chk(5, 8'h03, "R10 common march");
        set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk(4, 8'h01, "R10 thirty days"); chk(5, 8'h05, "R10 may");
    endtask

    task automatic t_roll_year();
        set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk_all(8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R11 year to century");
        set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk(7, 8'h00, "R11 century wrap");
        chk(6, 8'h00, "R11 year wrap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_track();
        t_ignored_write();
        t_read_hold();
        t_edit_load();
        t_edit_no_change();
        t_roll_time();
        t_roll_date();
        t_roll_year();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule